// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block keeps the status byte of a serial flash device and rules on every write-type command before the program/erase sequencer may start it. An SPI front-end hands it one decoded command per strobe, together with the 24-bit byte address and the data byte that goes with a status write. The block answers each write-type command with a one-cycle grant or deny pulse. On a grant it raises the write-in-progress bit and holds it until the sequencer reports completion.

Protection works in two layers. The first is software: a write enable latch, three block-protect bits that cover a growing upper part of the 64-sector array, and a status-write lock bit. The second is hardware: the lock bit combined with a low write-protect pin freezes the protect settings. The lock bit and the protect bits are treated as non-volatile. Only a power-on reset clears them. The ordinary reset clears only the latch and the busy bit.

Top module: `flash_wp_ctrl`

## Requirements
- R1: A power-on reset (`por_n` low) clears the whole status byte. An ordinary reset (`rst_n` low) clears only the latch (bit 1) and the busy bit (bit 0); the lock bit and the protect bits keep their values.
- R2: The status byte carries the busy flag in bit 0, the write enable latch in bit 1, the protect code in bits 4..2 (bit 4 is the most significant) and the lock bit in bit 7. Bits 6 and 5 read 0.
- R3: The command code `op` is decoded as follows: 0 enable writes, 1 disable writes, 2 read status, 3 page program, 4 sector erase, 5 bulk erase, 6 status write, 7 unused. Code 0 sets the latch and code 1 clears it. Neither code pulses grant or deny.
- R4: A program, sector erase, bulk erase or status write that arrives while the latch is 0 produces a deny pulse one cycle later and changes no status bit.
- R5: An accepted command produces a grant pulse one cycle after its strobe. In the same cycle the busy bit reads 1 and the latch reads 0. Grant and deny are never high together.
- R6: A `seq_done` pulse while busy clears the busy bit on the next clock.
- R7: The sector is address bits 23..18, so any address inside a sector selects it. Protect code k (k from 1 to 6) protects the top 2^(k-1) sectors. Code 7 protects all 64 sectors and code 0 protects none.
- R8: A page program or sector erase aimed at a protected sector is denied, and the latch stays 1.
- R9: A bulk erase is denied whenever the protect code is nonzero. With code 0 and the latch set, it is granted.
- R10: When the lock bit is 1 and `wp_n` is low, a status write is denied and bits 7 and 4..2 do not change.
- R11: An accepted status write loads the lock bit from `wdata[7]` and the protect code from `wdata[4:2]`. These new values are visible together with the grant.
- R12: While busy, every strobe is ignored: no grant, no deny, and no change to the latch. The read-status code and the unused code never pulse grant or deny.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset of the volatile bits, active low |
| por_n | input | 1 | Asynchronous power-on reset of all bits, active low |
| op_valid | input | 1 | Command strobe, one cycle per command |
| op | input | 3 | Decoded command code |
| addr | input | ADDR_W | Byte address of a program or erase |
| wdata | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| seq_done | input | 1 | Sequencer reports the end of the running cycle |
| status | output | 8 | Status byte |
| grant | output | 1 | Command accepted, one-cycle pulse |
| deny | output | 1 | Command refused, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: 64 sectors and a 24-bit address. It can therefore aim real addresses just inside and just outside the lowest protected sector for codes 1, 3, 5 and 7. It walks the latch through enable, disable and consumption around each write-type command. It also crosses the lock bit with both levels of the write-protect pin, holds the busy bit up while strobes arrive, and applies the two resets separately to show which bits each one clears.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int SECTOR_COUNT = 64,
  parameter int ADDR_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              op_valid,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wp_n,
  input  logic              seq_done,
  output logic [7:0]        status,
  output logic              grant,
  output logic              deny
);

  localparam int SEC_W = $clog2(SECTOR_COUNT);
  localparam logic [SEC_W:0] SEC_TOTAL = (SEC_W+1)'(SECTOR_COUNT);

  localparam logic [2:0] OP_WREN = 3'd0;
  localparam logic [2:0] OP_WRDI = 3'd1;
  localparam logic [2:0] OP_PP   = 3'd3;
  localparam logic [2:0] OP_SE   = 3'd4;
  localparam logic [2:0] OP_BE   = 3'd5;
  localparam logic [2:0] OP_WRSR = 3'd6;

  logic       lock_q;
  logic [2:0] bp_q;
  logic       wel_q;
  logic       wip_q;

  logic [SEC_W-1:0] sector;
  logic [SEC_W:0]   prot_cnt;
  logic [SEC_W:0]   prot_floor;
  logic             addr_prot;
  logic             live;
  logic             needs_wel;
  logic             allowed;
  logic             accept;
  logic             reject;

  assign sector     = addr[ADDR_W-1 -: SEC_W];
  assign prot_cnt   = SEC_TOTAL >> (3'd7 - bp_q);
  assign prot_floor = SEC_TOTAL - prot_cnt;
  assign addr_prot  = (bp_q != 3'd0) && ({1'b0, sector} >= prot_floor);

  assign live      = op_valid && !wip_q;
  assign needs_wel = (op == OP_PP) || (op == OP_SE) || (op == OP_BE) || (op == OP_WRSR);

  always_comb begin
    case (op)
      OP_PP, OP_SE: allowed = !addr_prot;
      OP_BE:        allowed = (bp_q == 3'd0);
      OP_WRSR:      allowed = !(lock_q && !wp_n);
      default:      allowed = 1'b0;
    endcase
  end

  assign accept = live && needs_wel && wel_q && allowed;
  assign reject = live && needs_wel && !accept;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q <= 1'b0;
      bp_q   <= 3'd0;
    end else if (accept && op == OP_WRSR) begin
      lock_q <= wdata[7];
      bp_q   <= wdata[4:2];
    end
  end

  logic vol_rst_n;
  assign vol_rst_n = rst_n & por_n;

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) begin
      wel_q <= 1'b0;
      wip_q <= 1'b0;
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= accept;
      deny  <= reject;
      if (accept)
        wel_q <= 1'b0;
      else if (live && op == OP_WREN)
        wel_q <= 1'b1;
      else if (live && op == OP_WRDI)
        wel_q <= 1'b0;
      if (accept)
        wip_q <= 1'b1;
      else if (seq_done)
        wip_q <= 1'b0;
    end
  end

  assign status = {lock_q, 2'b00, bp_q, wel_q, wip_q};

endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_n,
  input logic       op_valid,
  input logic [2:0] op,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       grant,
  input logic       deny
);

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(grant && deny)); // R5

  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    grant |-> (status[0] && !status[1])); // R5

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    status[0] |=> (!grant && !deny)); // R12

  AST_ENABLE_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (op_valid && op == 3'd0 && !status[0]) |=> status[1]); // R3

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (status[7] && !wp_n) |=> $stable({status[7], status[4:2]})); // R10

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    status[6:5] == 2'b00); // R2

  AST_NO_LATCH_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (op_valid && !status[1]) |=> !grant); // R4

endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .op_valid(op_valid), .op(op),
  .wp_n(wp_n), .status(status), .grant(grant), .deny(deny)
);

// File: tb/flash_wp_ctrl_bench.sv
`timescale 1ns/1ps
module flash_wp_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [23:0] addr = 24'h0;
  logic [7:0]  wdata = 8'h0;
  logic        wp_n = 1'b1;
  logic        seq_done = 1'b0;
  logic [7:0]  status;
  logic        grant;
  logic        deny;

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  flash_wp_ctrl u_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .op_valid(op_valid), .op(op),
    .addr(addr), .wdata(wdata), .wp_n(wp_n), .seq_done(seq_done),
    .status(status), .grant(grant), .deny(deny)
  );

  // {tag, op, addr, wdata, wp_n, exp_grant, exp_deny, exp_status}
  localparam int NV = 33;
  localparam logic [49:0] VEC [NV] = '{
    {4'd4,  3'd3, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00}, // R4 program without latch
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02}, // R3 enable
    {4'd3,  3'd1, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // R3 disable
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02},
    {4'd5,  3'd3, 24'h000100, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01}, // R5 grant
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02},
    {4'd11, 3'd6, 24'h000000, 8'h0C, 1'b1, 1'b1, 1'b0, 8'h0D}, // R11 code 3
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h0E},
    {4'd8,  3'd3, 24'hF00000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0E}, // R8 sector 60
    {4'd7,  3'd4, 24'hEFFFFF, 8'h00, 1'b1, 1'b1, 1'b0, 8'h0D}, // R7 sector 59 top byte
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h0E},
    {4'd9,  3'd5, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0E}, // R9 bulk with code 3
    {4'd11, 3'd6, 24'h000000, 8'h94, 1'b1, 1'b1, 1'b0, 8'h95}, // R11 lock + code 5
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h96},
    {4'd7,  3'd4, 24'hC00000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h96}, // R7 sector 48
    {4'd7,  3'd3, 24'hBFFFFF, 8'h00, 1'b1, 1'b1, 1'b0, 8'h95}, // R7 sector 47
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h96},
    {4'd10, 3'd6, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b1, 8'h96}, // R10 locked
    {4'd11, 3'd6, 24'h000000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01}, // R11 pin high
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02},
    {4'd9,  3'd5, 24'h123456, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01}, // R9 bulk granted
    {4'd12, 3'd7, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // R12 unused code
    {4'd12, 3'd2, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // R12 read status
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02},
    {4'd11, 3'd6, 24'h000000, 8'h04, 1'b1, 1'b1, 1'b0, 8'h05}, // R11 code 1
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h06},
    {4'd8,  3'd3, 24'hFC0000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h06}, // R8 sector 63
    {4'd7,  3'd3, 24'hFBFFFF, 8'h00, 1'b1, 1'b1, 1'b0, 8'h05}, // R7 sector 62
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h06},
    {4'd11, 3'd6, 24'h000000, 8'h1C, 1'b0, 1'b1, 1'b0, 8'h1D}, // R11 code 7, pin low unlocked
    {4'd3,  3'd0, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h1E},
    {4'd8,  3'd3, 24'h000000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h1E}, // R8 all protected
    {4'd11, 3'd6, 24'h000000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [23:0] a,
                        input logic [7:0] d, input logic w);
    @(negedge clk);
    op_valid = 1'b1; op = o; addr = a; wdata = d; wp_n = w;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic finish_cycle(input string req, input logic [7:0] exp_st);
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
    check(req, {24'h0, status}, {24'h0, exp_st});
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check("R1 por status", {24'h0, status}, 32'h0);
    check("R1 por grant/deny", {30'h0, grant, deny}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[49:46], i);
      run_op(v[45:43], v[42:19], v[18:11], v[10]);
      check({tg, " grant"}, {31'h0, grant}, {31'h0, v[9]});
      check({tg, " deny"},  {31'h0, deny},  {31'h0, v[8]});
      check({tg, " status"}, {24'h0, status}, {24'h0, v[7:0]});
      if (v[9]) finish_cycle("R6 done clears busy", v[7:0] & 8'hFE);
    end

    // R12: strobes ignored while busy
    run_op(3'd0, 24'h0, 8'h0, 1'b1);
    run_op(3'd3, 24'h000200, 8'h0, 1'b1);
    check("R5 busy grant", {31'h0, grant}, 32'h1);
    run_op(3'd0, 24'h0, 8'h0, 1'b1);
    check("R12 enable ignored while busy", {24'h0, status}, 32'h01);
    run_op(3'd3, 24'h0, 8'h0, 1'b1);
    check("R12 no grant/deny while busy", {30'h0, grant, deny}, 32'h0);
    finish_cycle("R6 done clears busy", 8'h00);

    // R1: ordinary reset keeps lock and protect bits
    run_op(3'd0, 24'h0, 8'h0, 1'b1);
    run_op(3'd6, 24'h0, 8'h88, 1'b1);
    finish_cycle("R11 lock + code 2", 8'h88);
    run_op(3'd0, 24'h0, 8'h0, 1'b1);
    check("R3 latch before reset", {24'h0, status}, 32'h8A);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rst keeps nonvolatile bits", {24'h0, status}, 32'h88);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 por clears all", {24'h0, status}, 32'h00);

    summary();
  end

endmodule